// File: doc/BRIEF.md
# Multi-Channel Beacon Event Timer

This block keeps the time base for a wireless MAC. It holds a 64-bit microsecond time-stamp counter, advanced by a one-cycle tick strobe from an external prescaler. It also runs five periodic event channels against the low 32 bits of that counter: the target beacon instant, an early alert for the beacon DMA engine, an early alert for beacon software, a TIM wake-up and a DTIM wake-up. Each channel holds a next-expiry value, a period and an enable bit. When the counter reaches or passes the next-expiry value, the channel raises a one-cycle pulse and moves its next-expiry forward by its period.

Software programs the block through one write port. Generic writes load a channel's next-expiry or period, with a unit selector that converts whole time units (1 TU = 1024 us) or eighths of a TU into microseconds by shifting. Two setup commands cover access-point or ad hoc operation. One loads the three beacon-side periods from a value in eighths of a TU, adds a fractional microsecond correction, and can clear the counter. The other arms the beacon channel and the two alert channels, with each alert placed ahead of the beacon by its own response time. A station arm command programs the beacon, TIM and DTIM channels from whole-TU values. The TIM and DTIM wake-ups are placed 3 TU ahead of the real instants. When the sleep duration makes the TIM period equal to the DTIM period, the first TIM wake is aligned to the next DTIM.

Top module: `beacon_event_timer`

## Requirements
- R1: After reset the time-stamp counter `tsf_o` is 0. It increases by exactly 1 at each clock edge where `tick_i` is high, and holds its value when `tick_i` is low.
- R2: When an enabled channel's next-expiry value is reached or passed, `event_o[i]` is high for one cycle, in the cycle after `tsf_o[31:0]` first shows a value at or beyond it. Reached means `tsf_o[31:0] - next` read as a signed 32-bit number is not negative. In the same cycle the next-expiry advances by the channel's period. `event_o` is 0 after reset.
- R3: Address `0x01 + i` writes channel i's next-expiry and address `0x06 + i` writes its period, each converted by `wr_unit_i`. The unit codes are: 00 = microseconds, 01 = eighths of a TU (value << 7), 10 = whole TU (value << 10), 11 = microseconds.
- R4: Address `0x00` writes the enable mask from `wr_data_i[4:0]`. The channel order is bit 0 beacon, bit 1 DMA alert, bit 2 software alert, bit 3 TIM, bit 4 DTIM. A disabled channel never pulses.
- R5: A next-expiry write produces no pulse in its own cycle. The new value is compared from the following cycle, so a value that has already passed fires one cycle later.
- R6: Address `0x0E` sets the periods of channels 0, 1 and 2 to `(wr_data_i[23:0] << 7)` plus the fraction register (address `0x0D`, in microseconds). If `wr_data_i[31]` is set, the counter is cleared to 0; the clear takes priority over a tick in the same cycle.
- R7: Address `0x0F` takes a beacon instant T in eighths of a TU. It loads channel 0 with T << 7, channel 1 with (T << 7) minus the DMA response time (address `0x0B`), and channel 2 with (T << 7) minus the software response time (address `0x0C`). It sets enables 0 to 2 and leaves enables 3 and 4 as they were.
- R8: Addresses `0x10` and `0x11` stage the station's next beacon and next DTIM in TU. The arm write at `0x12` carries the beacon interval in `[9:0]`, the DTIM period in `[19:10]` and the sleep duration in `[29:20]`, all in TU. It loads channel 0 with next = beacon << 10 and period = interval << 10. It loads channel 4 with next = (DTIM - 3) << 10 and period = max(DTIM period, sleep) << 10.
- R9: On the station arm, the TIM period P is max(interval, sleep) and the DTIM period D is max(DTIM period, sleep). Channel 3 gets period P << 10 and first expiry (X - 3) << 10, where X is the next DTIM when P equals D and the next beacon otherwise.
- R10: The station arm sets the enable mask to beacon, TIM and DTIM only, which stops the DMA and software alert channels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-microsecond strobe from the prescaler |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 5 | Register write address |
| wr_unit_i | input | 2 | Unit of a generic next or period write |
| wr_data_i | input | 32 | Register write data |
| tsf_o | output | 64 | Time-stamp counter in microseconds |
| event_o | output | 5 | One-cycle channel pulses, bit order as in R4 |

## Verification
The bench builds the block with its default widths (64-bit counter, 32-bit channel registers, 10-bit station fields, 3 TU of slack) and holds `tick_i` high, so one clock stands for one microsecond and one TU is 1024 cycles. With these values the whole-TU station programming can be followed through two periods of each channel in about thirteen thousand cycles. The same holds for the 3-TU slack and the DTIM alignment. The response-time offsets and the fractional period correction can be seen to the exact microsecond. The 32-bit compare window stays far from wrapping at this scale, so the bench reaches the passed-value catch-up only by writing a next-expiry that already lies behind the counter.

// File: rtl/bet_pkg.sv
// Shared constants for the beacon event timer: channel roles, the
// register address map, unit codes and the bit fields of the setup words.
package bet_pkg;

    localparam int NUM_CH  = 5;
    localparam int ADDR_W  = 5;

    localparam int CH_TBTT = 0;   // target beacon instant
    localparam int CH_DMA  = 1;   // DMA beacon alert
    localparam int CH_SWA  = 2;   // software beacon alert
    localparam int CH_TIM  = 3;   // TIM wake
    localparam int CH_DTIM = 4;   // DTIM wake

    typedef enum logic [1:0] {
        UNIT_US  = 2'b00,
        UNIT_E8  = 2'b01,
        UNIT_TU  = 2'b10,
        UNIT_RSV = 2'b11
    } unit_e;

    localparam int TU_SHIFT = 10;
    localparam int E8_SHIFT = 7;

    localparam int A_EN       = 'h00;
    localparam int A_NEXT0    = 'h01;
    localparam int A_PER0     = 'h06;
    localparam int A_DMA_RSP  = 'h0B;
    localparam int A_SW_RSP   = 'h0C;
    localparam int A_FRAC     = 'h0D;
    localparam int A_AP_PER   = 'h0E;
    localparam int A_AP_START = 'h0F;
    localparam int A_STA_TBTT = 'h10;
    localparam int A_STA_DTIM = 'h11;
    localparam int A_STA_ARM  = 'h12;

    localparam int AP_PER_W   = 24;   // period field width in the AP period word
    localparam int TSF_RST_B  = 31;   // counter-clear flag in the AP period word

    localparam logic [NUM_CH-1:0] AP_EN_MASK =
        NUM_CH'((1 << CH_TBTT) | (1 << CH_DMA) | (1 << CH_SWA));
    localparam logic [NUM_CH-1:0] STA_EN_MASK =
        NUM_CH'((1 << CH_TBTT) | (1 << CH_TIM) | (1 << CH_DTIM));

endpackage

// File: rtl/bet_unit_conv.sv
// Unit converter: turns a value in microseconds, eighths of a TU or whole
// TU into microseconds by shifting. Assumes the caller keeps the value
// small enough that the shifted result fits W bits; overflow is dropped.
module bet_unit_conv
    import bet_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] val_i,
    input  logic [1:0]   unit_i,
    output logic [W-1:0] us_o
);

    // Select the shift that matches the unit code.
    always_comb begin
        case (unit_e'(unit_i))
            UNIT_E8: us_o = val_i << E8_SHIFT;
            UNIT_TU: us_o = val_i << TU_SHIFT;
            default: us_o = val_i;
        endcase
    end

endmodule

// File: rtl/bet_tsf.sv
// Time-stamp counter: counts microsecond ticks. A clear request wins
// over a tick in the same cycle. Assumes tick_i is a one-cycle strobe.
module bet_tsf #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         clr_i,
    output logic [W-1:0] tsf_o
);

    logic [W-1:0] cnt_q;

    // Advance, clear or hold the counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= cnt_q + W'(1);
        end
    end

    assign tsf_o = cnt_q;

endmodule

// File: rtl/bet_channel.sv
// One periodic event channel. It compares the low counter bits against
// its next-expiry with a signed-difference test, so a value already
// passed still fires. On a hit it pulses for one cycle and adds its
// period. A next-expiry load blocks the hit in its own cycle. Assumes the
// gap between counter and next-expiry stays below half the W-bit range.
module bet_channel #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic [W-1:0] tsf_lo_i,
    input  logic         ld_next_i,
    input  logic [W-1:0] next_val_i,
    input  logic         ld_per_i,
    input  logic [W-1:0] per_val_i,
    output logic         fire_o,
    output logic [W-1:0] next_o,
    output logic [W-1:0] per_o
);

    logic [W-1:0] next_q;
    logic [W-1:0] per_q;
    logic         fire_q;
    logic [W-1:0] gap;
    logic         reached;
    logic         hit;

    // Reached-or-passed test on the wrapped difference.
    always_comb begin
        gap     = tsf_lo_i - next_q;
        reached = ~gap[W-1];
        hit     = en_i & reached & ~ld_next_i;
    end

    // Hold next-expiry and period, register the pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_q <= '0;
            per_q  <= '0;
            fire_q <= 1'b0;
        end else begin
            fire_q <= hit;
            if (ld_next_i) begin
                next_q <= next_val_i;
            end else if (hit) begin
                next_q <= next_q + per_q;
            end
            if (ld_per_i) begin
                per_q <= per_val_i;
            end
        end
    end

    assign fire_o = fire_q;
    assign next_o = next_q;
    assign per_o  = per_q;

endmodule

// File: rtl/bet_cfg.sv
// Write-port decoder. Turns generic writes, the access-point setup words
// and the station arm word into per-channel load strobes and values. It
// owns the enable mask, the two response times, the period fraction and
// the staged station instants. Assumes W is at least 32 and that
// 3 * FIELD_W fits in the data word.
module bet_cfg
    import bet_pkg::*;
#(
    parameter int W        = 32,
    parameter int FIELD_W  = 10,
    parameter int SLACK_TU = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en_i,
    input  logic [ADDR_W-1:0]        wr_addr_i,
    input  logic [1:0]               wr_unit_i,
    input  logic [W-1:0]             wr_data_i,
    output logic [NUM_CH-1:0]        en_o,
    output logic [NUM_CH-1:0]        ld_next_o,
    output logic [NUM_CH-1:0][W-1:0] next_val_o,
    output logic [NUM_CH-1:0]        ld_per_o,
    output logic [NUM_CH-1:0][W-1:0] per_val_o,
    output logic                     tsf_clr_o,
    output logic                     sta_arm_o
);

    logic [NUM_CH-1:0] en_q;
    logic [W-1:0]      dma_rsp_q;
    logic [W-1:0]      sw_rsp_q;
    logic [W-1:0]      frac_q;
    logic [W-1:0]      sta_tbtt_q;
    logic [W-1:0]      sta_dtim_q;

    logic [W-1:0]      conv_us;
    logic [W-1:0]      ap_per_us;
    logic [W-1:0]      ap_start_us;
    logic [W-1:0]      bint_tu;
    logic [W-1:0]      dtimp_tu;
    logic [W-1:0]      sleep_tu;
    logic [W-1:0]      tim_per_tu;
    logic [W-1:0]      dtim_per_tu;
    logic [W-1:0]      tim_first_tu;
    logic              is_ap_per;
    logic              is_ap_start;
    logic              is_sta_arm;

    bet_unit_conv #(.W(W)) u_conv (
        .val_i  (wr_data_i),
        .unit_i (wr_unit_i),
        .us_o   (conv_us)
    );

    // Decode the setup commands.
    always_comb begin
        is_ap_per   = wr_en_i && (wr_addr_i == ADDR_W'(A_AP_PER));
        is_ap_start = wr_en_i && (wr_addr_i == ADDR_W'(A_AP_START));
        is_sta_arm  = wr_en_i && (wr_addr_i == ADDR_W'(A_STA_ARM));
    end

    // Access-point arithmetic: shared period and beacon instant in microseconds.
    always_comb begin
        ap_per_us   = (W'(wr_data_i[AP_PER_W-1:0]) << E8_SHIFT) + frac_q;
        ap_start_us = wr_data_i << E8_SHIFT;
    end

    // Station arithmetic: effective periods and the first TIM instant, in TU.
    always_comb begin
        bint_tu      = W'(wr_data_i[FIELD_W-1:0]);
        dtimp_tu     = W'(wr_data_i[2*FIELD_W-1:FIELD_W]);
        sleep_tu     = W'(wr_data_i[3*FIELD_W-1:2*FIELD_W]);
        tim_per_tu   = (sleep_tu > bint_tu)  ? sleep_tu : bint_tu;
        dtim_per_tu  = (sleep_tu > dtimp_tu) ? sleep_tu : dtimp_tu;
        tim_first_tu = (tim_per_tu == dtim_per_tu) ? sta_dtim_q : sta_tbtt_q;
    end

    // Build per-channel load strobes and values from all write sources.
    always_comb begin
        ld_next_o  = '0;
        ld_per_o   = '0;
        next_val_o = '0;
        per_val_o  = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (wr_en_i && (wr_addr_i == ADDR_W'(A_NEXT0 + i))) begin
                ld_next_o[i]  = 1'b1;
                next_val_o[i] = conv_us;
            end
            if (wr_en_i && (wr_addr_i == ADDR_W'(A_PER0 + i))) begin
                ld_per_o[i]  = 1'b1;
                per_val_o[i] = conv_us;
            end
        end
        if (is_ap_per) begin
            ld_per_o[CH_TBTT]  = 1'b1;
            ld_per_o[CH_DMA]   = 1'b1;
            ld_per_o[CH_SWA]   = 1'b1;
            per_val_o[CH_TBTT] = ap_per_us;
            per_val_o[CH_DMA]  = ap_per_us;
            per_val_o[CH_SWA]  = ap_per_us;
        end
        if (is_ap_start) begin
            ld_next_o[CH_TBTT]  = 1'b1;
            ld_next_o[CH_DMA]   = 1'b1;
            ld_next_o[CH_SWA]   = 1'b1;
            next_val_o[CH_TBTT] = ap_start_us;
            next_val_o[CH_DMA]  = ap_start_us - dma_rsp_q;
            next_val_o[CH_SWA]  = ap_start_us - sw_rsp_q;
        end
        if (is_sta_arm) begin
            ld_next_o[CH_TBTT]  = 1'b1;
            ld_next_o[CH_TIM]   = 1'b1;
            ld_next_o[CH_DTIM]  = 1'b1;
            ld_per_o[CH_TBTT]   = 1'b1;
            ld_per_o[CH_TIM]    = 1'b1;
            ld_per_o[CH_DTIM]   = 1'b1;
            next_val_o[CH_TBTT] = sta_tbtt_q << TU_SHIFT;
            next_val_o[CH_TIM]  = (tim_first_tu - W'(SLACK_TU)) << TU_SHIFT;
            next_val_o[CH_DTIM] = (sta_dtim_q - W'(SLACK_TU)) << TU_SHIFT;
            per_val_o[CH_TBTT]  = bint_tu << TU_SHIFT;
            per_val_o[CH_TIM]   = tim_per_tu << TU_SHIFT;
            per_val_o[CH_DTIM]  = dtim_per_tu << TU_SHIFT;
        end
    end

    // Counter clear request and station arm marker.
    always_comb begin
        tsf_clr_o = is_ap_per && wr_data_i[TSF_RST_B];
        sta_arm_o = is_sta_arm;
    end

    // Hold the enable mask and the scalar setup registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q       <= '0;
            dma_rsp_q  <= '0;
            sw_rsp_q   <= '0;
            frac_q     <= '0;
            sta_tbtt_q <= '0;
            sta_dtim_q <= '0;
        end else if (wr_en_i) begin
            case (int'(wr_addr_i))
                A_EN:       en_q       <= wr_data_i[NUM_CH-1:0];
                A_DMA_RSP:  dma_rsp_q  <= wr_data_i;
                A_SW_RSP:   sw_rsp_q   <= wr_data_i;
                A_FRAC:     frac_q     <= wr_data_i;
                A_AP_START: en_q       <= en_q | AP_EN_MASK;
                A_STA_TBTT: sta_tbtt_q <= wr_data_i;
                A_STA_DTIM: sta_dtim_q <= wr_data_i;
                A_STA_ARM:  en_q       <= STA_EN_MASK;
                default:    en_q       <= en_q;
            endcase
        end
    end

    assign en_o = en_q;

endmodule

// File: rtl/beacon_event_timer.sv
// Top of the beacon event timer: one time-stamp counter, one write-port
// decoder and NUM_CH event channels that compare against the low REG_W
// counter bits. Assumes one tick per microsecond on tick_i.
module beacon_event_timer
    import bet_pkg::*;
#(
    parameter int TSF_W    = 64,
    parameter int REG_W    = 32,
    parameter int FIELD_W  = 10,
    parameter int SLACK_TU = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [1:0]        wr_unit_i,
    input  logic [REG_W-1:0]  wr_data_i,
    output logic [TSF_W-1:0]  tsf_o,
    output logic [NUM_CH-1:0] event_o
);

    logic [NUM_CH-1:0]            ch_en;
    logic [NUM_CH-1:0]            ld_next;
    logic [NUM_CH-1:0]            ld_per;
    logic [NUM_CH-1:0][REG_W-1:0] next_val;
    logic [NUM_CH-1:0][REG_W-1:0] per_val;
    logic [NUM_CH-1:0][REG_W-1:0] ch_next;
    logic [NUM_CH-1:0][REG_W-1:0] ch_per;
    logic                         tsf_clr;
    logic                         sta_arm;
    logic [REG_W-1:0]             tsf_lo;

    bet_tsf #(.W(TSF_W)) u_tsf (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick_i),
        .clr_i  (tsf_clr),
        .tsf_o  (tsf_o)
    );

    assign tsf_lo = tsf_o[REG_W-1:0];

    bet_cfg #(
        .W        (REG_W),
        .FIELD_W  (FIELD_W),
        .SLACK_TU (SLACK_TU)
    ) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en_i),
        .wr_addr_i  (wr_addr_i),
        .wr_unit_i  (wr_unit_i),
        .wr_data_i  (wr_data_i),
        .en_o       (ch_en),
        .ld_next_o  (ld_next),
        .next_val_o (next_val),
        .ld_per_o   (ld_per),
        .per_val_o  (per_val),
        .tsf_clr_o  (tsf_clr),
        .sta_arm_o  (sta_arm)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        bet_channel #(.W(REG_W)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .en_i       (ch_en[g]),
            .tsf_lo_i   (tsf_lo),
            .ld_next_i  (ld_next[g]),
            .next_val_i (next_val[g]),
            .ld_per_i   (ld_per[g]),
            .per_val_i  (per_val[g]),
            .fire_o     (event_o[g]),
            .next_o     (ch_next[g]),
            .per_o      (ch_per[g])
        );
    end

endmodule

// File: rtl/bet_checker.sv
// Property checker for the beacon event timer, bound to the top module.
// It watches the counter, the setup strobes and every channel's state.
module bet_checker
    import bet_pkg::*;
#(
    parameter int REG_W = 32,
    parameter int TSF_W = 64
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            tick_i,
    input logic                            tsf_clr_i,
    input logic                            sta_arm_i,
    input logic [TSF_W-1:0]                tsf_i,
    input logic [NUM_CH-1:0]               en_i,
    input logic [NUM_CH-1:0]               ld_next_i,
    input logic [NUM_CH-1:0]               fire_i,
    input logic [NUM_CH-1:0][REG_W-1:0]    next_i,
    input logic [NUM_CH-1:0][REG_W-1:0]    per_i
);

    // R1
    tsf_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !tsf_clr_i) |=> (tsf_i == $past(tsf_i) + TSF_W'(1)));

    // R1
    tsf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !tsf_clr_i) |=> $stable(tsf_i));

    // R6
    tsf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tsf_clr_i |=> (tsf_i == '0));

    // R10
    sta_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sta_arm_i |=> (en_i == STA_EN_MASK));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        // R2
        advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
            fire_i[g] |-> (next_i[g] == $past(next_i[g]) + $past(per_i[g])));

        // R4
        disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !en_i[g] |=> !fire_i[g]);

        // R5
        write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ld_next_i[g] |=> !fire_i[g]);
    end

endmodule

bind beacon_event_timer bet_checker #(
    .REG_W (REG_W),
    .TSF_W (TSF_W)
) u_bet_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .tsf_clr_i (tsf_clr),
    .sta_arm_i (sta_arm),
    .tsf_i     (tsf_o),
    .en_i      (ch_en),
    .ld_next_i (ld_next),
    .fire_i    (event_o),
    .next_i    (ch_next),
    .per_i     (ch_per)
);

// File: tb/beacon_event_timer_test.sv
// Bench for the beacon event timer: a vector table of single-channel
// programs, then directed tests for reset, the counter, the access-point
// setup, the station arm, DTIM alignment and write-time behaviour.
module beacon_event_timer_test;

    localparam int NCH = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b1;
    logic        wr_en_i = 1'b0;
    logic [4:0]  wr_addr_i = '0;
    logic [1:0]  wr_unit_i = '0;
    logic [31:0] wr_data_i = '0;
    logic [63:0] tsf_o;
    logic [4:0]  event_o;

    int nchk = 0;
    int nerr = 0;

    beacon_event_timer uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_unit_i (wr_unit_i),
        .wr_data_i (wr_data_i),
        .tsf_o     (tsf_o),
        .event_o   (event_o)
    );

    always #10 clk = ~clk;

    // Pulse monitor: counts pulses and records the counter value that triggered each.
    longint unsigned hist [NCH][64];
    int              cnt [NCH];
    longint unsigned prev_tsf = 0;

    initial begin
        for (int i = 0; i < NCH; i++) cnt[i] = 0;
    end

    always @(posedge clk) begin
        #5;
        for (int i = 0; i < NCH; i++) begin
            if (rst_n && event_o[i]) begin
                hist[i][cnt[i] % 64] = prev_tsf;
                cnt[i] = cnt[i] + 1;
            end
        end
        prev_tsf = tsf_o;
    end

    task automatic check(input string req, input longint unsigned act, input longint unsigned exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [1:0] u, input logic [31:0] d);
        @(negedge clk);
        wr_en_i   = 1'b1;
        wr_addr_i = 5'(a);
        wr_unit_i = u;
        wr_data_i = d;
        @(negedge clk);
        wr_en_i   = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_pulses(input int ch, input int base, input int n);
        int lim = 0;
        while (cnt[ch] < base + n && lim < 40000) begin
            @(negedge clk);
            lim++;
        end
        @(negedge clk);
    endtask

    // Vector table: unit, raw next, raw period, channel, expected first fire, expected period.
    localparam int NV = 5;
    localparam logic [1:0] V_UNIT [NV] = '{2'b00, 2'b01, 2'b10, 2'b11, 2'b01};
    localparam int V_NEXT [NV] = '{100, 2, 1, 37, 5};
    localparam int V_PER  [NV] = '{50, 1, 1, 9, 3};
    localparam int V_CH   [NV] = '{0, 3, 4, 1, 2};
    localparam int V_EXPF [NV] = '{100, 256, 1024, 37, 640};
    localparam int V_EXPP [NV] = '{50, 128, 1024, 9, 384};

    initial begin
        int b [NCH];
        longint unsigned t0;

        // Reset state
        do_reset();
        check("R1 reset counter", tsf_o, 0);
        check("R2 reset pulses", event_o, 0);

        // Counter advance and hold
        t0 = tsf_o;
        repeat (10) @(negedge clk);
        check("R1 tick advance", tsf_o, t0 + 10);
        tick_i = 1'b0;
        @(negedge clk);
        t0 = tsf_o;
        repeat (20) @(negedge clk);
        check("R1 tick hold", tsf_o, t0);
        tick_i = 1'b1;

        // Table of single-channel programs with unit conversion
        for (int v = 0; v < NV; v++) begin
            int ch = V_CH[v];
            int base;
            do_reset();
            wr(5'h06 + ch, V_UNIT[v], 32'(V_PER[v]));
            wr(5'h01 + ch, V_UNIT[v], 32'(V_NEXT[v]));
            base = cnt[ch];
            wr(5'h00, 2'b00, 32'(1 << ch));
            wait_pulses(ch, base, 2);
            check($sformatf("R3 R2 vector %0d first", v), hist[ch][base % 64], longint'(V_EXPF[v]));
            check($sformatf("R3 R2 vector %0d second", v), hist[ch][(base + 1) % 64],
                  longint'(V_EXPF[v] + V_EXPP[v]));
        end

        // Access-point setup: offsets and corrected period
        do_reset();
        wr(5'h0D, 2'b00, 32'd3);
        wr(5'h0B, 2'b00, 32'd200);
        wr(5'h0C, 2'b00, 32'd500);
        wr(5'h0E, 2'b00, 32'd8);
        for (int i = 0; i < NCH; i++) b[i] = cnt[i];
        wr(5'h0F, 2'b00, 32'd16);
        wait_pulses(0, b[0], 2);
        check("R7 beacon first", hist[0][b[0] % 64], 2048);
        check("R6 beacon period", hist[0][(b[0] + 1) % 64], 2048 + 1027);
        check("R7 dma alert first", hist[1][b[1] % 64], 1848);
        check("R6 dma alert period", hist[1][(b[1] + 1) % 64], 1848 + 1027);
        check("R7 sw alert first", hist[2][b[2] % 64], 1548);
        check("R6 sw alert period", hist[2][(b[2] + 1) % 64], 1548 + 1027);
        check("R7 TIM/DTIM untouched", longint'(cnt[3] + cnt[4]), longint'(b[3] + b[4]));

        // Counter clear flag
        wr(5'h0E, 2'b00, 32'h8000_0008);
        check("R6 counter clear", tsf_o, 0);

        // Station arm, no alignment
        do_reset();
        wr(5'h10, 2'b00, 32'd10);
        wr(5'h11, 2'b00, 32'd12);
        for (int i = 0; i < NCH; i++) b[i] = cnt[i];
        wr(5'h12, 2'b00, 32'(2 | (4 << 10)));
        wait_pulses(4, b[4], 2);
        check("R8 station beacon first", hist[0][b[0] % 64], 10240);
        check("R8 station beacon period", hist[0][(b[0] + 1) % 64], 12288);
        check("R9 TIM first from beacon", hist[3][b[3] % 64], 7168);
        check("R9 TIM period", hist[3][(b[3] + 1) % 64], 9216);
        check("R8 DTIM first", hist[4][b[4] % 64], 9216);
        check("R8 DTIM period", hist[4][(b[4] + 1) % 64], 13312);
        check("R10 alerts silent", longint'(cnt[1] + cnt[2]), longint'(b[1] + b[2]));

        // Station arm with sleep equal to DTIM period: alignment, alerts stopped
        do_reset();
        wr(5'h10, 2'b00, 32'd10);
        wr(5'h11, 2'b00, 32'd12);
        b[1] = cnt[1];
        wr(5'h00, 2'b00, 32'h06);
        repeat (3) @(negedge clk);
        check("R4 enabled alert pulses", longint'(cnt[1] > b[1]), 1);
        wr(5'h12, 2'b00, 32'(2 | (4 << 10) | (4 << 20)));
        @(negedge clk);
        for (int i = 0; i < NCH; i++) b[i] = cnt[i];
        wait_pulses(3, b[3], 2);
        check("R9 TIM aligned to DTIM", hist[3][b[3] % 64], 9216);
        check("R9 TIM sleep period", hist[3][(b[3] + 1) % 64], 13312);
        check("R10 alerts stopped", longint'(cnt[1] + cnt[2]), longint'(b[1] + b[2]));

        // Next-expiry write behind the counter while enabled
        do_reset();
        wr(5'h01, 2'b00, 32'd1000000);
        wr(5'h06, 2'b00, 32'd100000);
        wr(5'h00, 2'b00, 32'h01);
        repeat (50) @(negedge clk);
        b[0] = cnt[0];
        wr(5'h01, 2'b00, 32'd5);
        check("R5 no pulse on write", event_o[0], 0);
        @(negedge clk);
        check("R5 catch-up pulse", event_o[0], 1);
        repeat (20) @(negedge clk);
        check("R5 R2 single catch-up", longint'(cnt[0]), longint'(b[0] + 1));

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule